// File: doc/BRIEF.md
# Storage Command Queue Task Manager

This block is the device-side bookkeeping for a storage protocol that lets the host queue several transfers before running them. It sits behind a command parser and receives one frame per cycle, made of a 6-bit command index and a 32-bit argument. A queue slot is set up in two steps. A parameters frame gives the slot number, the direction, the priority and the block count. An address frame that must come next gives the start block address. The slot then waits in a pending state for a fixed preparation time and becomes ready.

The host polls a ready bitmap through a status frame. It starts a ready slot with an execute frame whose kind must match the slot's direction. The slot stays active until the data engine pulses transfer-done. A management frame drops one slot or the whole queue. An enable input and a 5-bit depth field (depth = field + 1) configure the queue. Any frame that breaks a rule raises a one-cycle error flag and changes nothing.

Top module: `cmdq_task_mgr`

## Requirements
- R1: After reset every slot is unused and rspValid, errFlag and execStart are low. A status frame with argument bit 15 set then returns 0.
- R2: A parameters frame (index 44) takes the slot ID from bits 20:16, read direction from bit 30 (1 = read), high priority from bit 23 and the block count from bits 15:0. All other argument bits have no effect.
- R3: An address frame (index 45) that directly follows an accepted parameters frame stores the 32-bit argument as the start address and puts the slot in pending. The slot becomes ready PREP_CYCLES clock edges after the edge that accepted the address frame.
- R4: An address frame raises errFlag and changes no state in two cases: the previous frame was not an accepted parameters frame, or the slot it targets is not unused.
- R5: A status frame (index 13) gives rspValid one cycle later. With bit 15 set, rspData bit i is 1 exactly when slot i was ready before that edge. With bit 15 clear, rspData copies legacyStatus.
- R6: An execute frame (46 = read, 47 = write, slot in bits 20:16) on a ready slot of the matching direction makes the slot active. One cycle later it pulses execStart, with execId, execRead, execHighPrio, execAddr and execCount taken from that slot.
- R7: An execute frame raises errFlag and changes nothing in three cases: the slot is not ready, the direction does not match, or the slot ID is at or above the depth.
- R8: A transfer-done pulse returns every active slot to unused, so its ID can be queued again.
- R9: A management frame (index 48) with op-code bits 3:0 = 1 clears every slot. Op-code 2 clears only the slot named in bits 20:16. Any other op-code, or op-code 2 with an out-of-range ID, raises errFlag.
- R10: The depth is the smaller of cfgDepthN+1 and NUM_SLOTS. A parameters frame with an ID at or above the depth raises errFlag. Status bits at or above the depth always read 0.
- R11: While cfgEnable is low, all slots are cleared and frames 44 to 48 raise errFlag. Status frames are still answered.
- R12: Within one cycle a clear beats a slot's transition to ready, and an execute on one slot beats transfer-done for that slot. A status frame reports the state from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A decoded frame is present this cycle |
| cmdIndex | input | 6 | Command index of the frame |
| cmdArg | input | 32 | Command argument |
| xferDone | input | 1 | Data transfer of the active slot has finished |
| cfgEnable | input | 1 | Queue mode enable |
| cfgDepthN | input | 5 | Depth field; depth = value + 1 |
| legacyStatus | input | 32 | Normal device status returned for plain status frames |
| rspValid | output | 1 | Response word valid |
| rspData | output | 32 | Response word (ready bitmap or legacy status) |
| errFlag | output | 1 | One-cycle pulse for a rejected frame |
| execStart | output | 1 | One-cycle pulse: a slot starts its transfer |
| execId | output | 5 | Slot that started |
| execRead | output | 1 | Started slot is a read |
| execHighPrio | output | 1 | Started slot has high priority |
| execAddr | output | 32 | Start block address of the started slot |
| execCount | output | 16 | Block count of the started slot |

## Verification
The two risky coincidences are a slot finishing its preparation in the same cycle that a status frame or a single-slot clear arrives, and transfer-done arriving in the same cycle that another slot is executed. The bench times the clear frame to land exactly on the edge where the slot would turn ready. It then checks that the slot can be queued again without error. It also samples status on that edge and the next one and expects 0 and then the slot's bit. For the execute/done overlap, it issues an execute for a second slot while pulsing done. It then confirms that the first slot's ID is free again and that the second slot is still held.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ID_W      = 5;
  localparam int MAX_TASKS = 32;
  localparam int CNT_W     = 16;
  localparam int ADDR_W    = 32;
  localparam int IDX_W     = 6;

  localparam logic [IDX_W-1:0] IDX_STATUS  = 6'd13;
  localparam logic [IDX_W-1:0] IDX_PARAMS  = 6'd44;
  localparam logic [IDX_W-1:0] IDX_ADDR    = 6'd45;
  localparam logic [IDX_W-1:0] IDX_EXEC_RD = 6'd46;
  localparam logic [IDX_W-1:0] IDX_EXEC_WR = 6'd47;
  localparam logic [IDX_W-1:0] IDX_MGMT    = 6'd48;

  localparam logic [3:0] OP_CLR_ALL = 4'h1;
  localparam logic [3:0] OP_CLR_ONE = 4'h2;

  typedef enum logic [1:0] {T_UNUSED, T_PENDING, T_READY, T_ACTIVE} slot_state_e;

  // strobes from control to the slot store
  typedef struct packed {
    logic              commit;
    logic              exec;
    logic              clrOne;
    logic              clrAll;
    logic [ID_W-1:0]   id;
    logic              dirRead;
    logic              highPrio;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] addr;
  } qstrobe_t;
endpackage

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [IDX_W-1:0]     cmdIndex,
  input  logic [31:0]          cmdArg,
  input  logic                 cfgEnable,
  input  logic [4:0]           cfgDepthN,
  input  logic [31:0]          legacyStatus,
  input  logic [MAX_TASKS-1:0] readyMap,
  input  logic [MAX_TASKS-1:0] busyMap,
  input  logic [MAX_TASKS-1:0] dirMap,
  output qstrobe_t             strb,
  output logic                 rspValid,
  output logic [31:0]          rspData,
  output logic                 errFlag
);
  logic [5:0]           depthEff;
  logic [MAX_TASKS-1:0] depthMask;
  logic [ID_W-1:0]      argId;
  logic                 argInRange;
  logic                 wantRead;
  logic                 errNext, rspNext, stageLoad;

  logic                 stageValid;
  logic [ID_W-1:0]      stageId;
  logic                 stageDir, stagePrio;
  logic [CNT_W-1:0]     stageCount;

  logic unusedArgBits;
  assign unusedArgBits = ^{cmdArg[31], cmdArg[29:24], cmdArg[22:21]};

  assign argId    = cmdArg[20:16];
  assign wantRead = (cmdIndex == IDX_EXEC_RD);

  always_comb begin
    depthEff = {1'b0, cfgDepthN} + 6'd1;
    if (depthEff > 6'(NUM_SLOTS)) depthEff = 6'(NUM_SLOTS);
    for (int i = 0; i < MAX_TASKS; i++) depthMask[i] = (i < int'(depthEff));
  end

  assign argInRange = ({1'b0, argId} < depthEff);

  always_comb begin
    strb        = '0;
    strb.clrAll = !cfgEnable;
    errNext     = 1'b0;
    rspNext     = 1'b0;
    stageLoad   = 1'b0;
    if (cmdValid) begin
      case (cmdIndex)
        IDX_PARAMS: begin
          if (!cfgEnable || !argInRange) errNext = 1'b1;
          else stageLoad = 1'b1;
        end
        IDX_ADDR: begin
          if (!cfgEnable || !stageValid || busyMap[stageId]) errNext = 1'b1;
          else begin
            strb.commit   = 1'b1;
            strb.id       = stageId;
            strb.dirRead  = stageDir;
            strb.highPrio = stagePrio;
            strb.count    = stageCount;
            strb.addr     = cmdArg;
          end
        end
        IDX_EXEC_RD, IDX_EXEC_WR: begin
          if (!cfgEnable || !argInRange || !readyMap[argId] || (dirMap[argId] != wantRead))
            errNext = 1'b1;
          else begin
            strb.exec = 1'b1;
            strb.id   = argId;
          end
        end
        IDX_MGMT: begin
          if (!cfgEnable) errNext = 1'b1;
          else if (cmdArg[3:0] == OP_CLR_ALL) strb.clrAll = 1'b1;
          else if (cmdArg[3:0] == OP_CLR_ONE && argInRange) begin
            strb.clrOne = 1'b1;
            strb.id     = argId;
          end else errNext = 1'b1;
        end
        IDX_STATUS: rspNext = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag    <= 1'b0;
      rspValid   <= 1'b0;
      rspData    <= '0;
      stageValid <= 1'b0;
      stageId    <= '0;
      stageDir   <= 1'b0;
      stagePrio  <= 1'b0;
      stageCount <= '0;
    end else begin
      errFlag  <= errNext;
      rspValid <= rspNext;
      if (rspNext) rspData <= cmdArg[15] ? (readyMap & depthMask) : legacyStatus;
      if (!cfgEnable)    stageValid <= 1'b0;
      else if (cmdValid) stageValid <= stageLoad;
      if (stageLoad) begin
        stageId    <= argId;
        stageDir   <= cmdArg[30];
        stagePrio  <= cmdArg[23];
        stageCount <= cmdArg[15:0];
      end
    end
  end
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store
  import cmdq_pkg::*;
#(
  parameter int NUM_SLOTS   = 32,
  parameter int PREP_CYCLES = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  qstrobe_t             strb,
  input  logic                 xferDone,
  output logic [MAX_TASKS-1:0] readyMap,
  output logic [MAX_TASKS-1:0] busyMap,
  output logic [MAX_TASKS-1:0] dirMap,
  output logic                 execStart,
  output logic [ID_W-1:0]      execId,
  output logic                 execRead,
  output logic                 execHighPrio,
  output logic [ADDR_W-1:0]    execAddr,
  output logic [CNT_W-1:0]     execCount
);
  localparam int PREP_W = $clog2(PREP_CYCLES + 1);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic              slotDir  [NUM_SLOTS];
  logic              slotPrio [NUM_SLOTS];
  logic [ADDR_W-1:0] slotAddr [NUM_SLOTS];
  logic [CNT_W-1:0]  slotCount[NUM_SLOTS];

  for (genvar i = 0; i < MAX_TASKS; i++) begin : g_slot
    if (i < NUM_SLOTS) begin : g_live
      slot_state_e       stateQ;
      logic [PREP_W-1:0] prepQ;
      logic              dirQ, prioQ;
      logic [ADDR_W-1:0] addrQ;
      logic [CNT_W-1:0]  countQ;
      logic              hit;

      assign hit = (strb.id == ID_W'(i));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          stateQ <= T_UNUSED;
          prepQ  <= '0;
        end else if (strb.clrAll || (strb.clrOne && hit)) begin
          stateQ <= T_UNUSED;
        end else if (strb.commit && hit) begin
          stateQ <= T_PENDING;
          prepQ  <= PREP_W'(PREP_CYCLES);
        end else if (strb.exec && hit) begin
          stateQ <= T_ACTIVE;
        end else begin
          case (stateQ)
            T_PENDING: begin
              if (prepQ == PREP_W'(1)) stateQ <= T_READY;
              else prepQ <= prepQ - PREP_W'(1);
            end
            T_ACTIVE: if (xferDone) stateQ <= T_UNUSED;
            default: ;
          endcase
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          dirQ   <= 1'b0;
          prioQ  <= 1'b0;
          addrQ  <= '0;
          countQ <= '0;
        end else if (strb.commit && hit) begin
          dirQ   <= strb.dirRead;
          prioQ  <= strb.highPrio;
          addrQ  <= strb.addr;
          countQ <= strb.count;
        end
      end

      assign readyMap[i]  = (stateQ == T_READY);
      assign busyMap[i]   = (stateQ != T_UNUSED);
      assign dirMap[i]    = dirQ;
      assign slotDir[i]   = dirQ;
      assign slotPrio[i]  = prioQ;
      assign slotAddr[i]  = addrQ;
      assign slotCount[i] = countQ;
    end else begin : g_none
      assign readyMap[i] = 1'b0;
      assign busyMap[i]  = 1'b1;
      assign dirMap[i]   = 1'b0;
    end
  end

  logic [SLOT_W-1:0] selIdx;
  assign selIdx = strb.id[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      execStart    <= 1'b0;
      execId       <= '0;
      execRead     <= 1'b0;
      execHighPrio <= 1'b0;
      execAddr     <= '0;
      execCount    <= '0;
    end else begin
      execStart <= strb.exec;
      if (strb.exec) begin
        execId       <= strb.id;
        execRead     <= slotDir[selIdx];
        execHighPrio <= slotPrio[selIdx];
        execAddr     <= slotAddr[selIdx];
        execCount    <= slotCount[selIdx];
      end
    end
  end
endmodule

// File: rtl/cmdq_task_mgr.sv
module cmdq_task_mgr
  import cmdq_pkg::*;
#(
  parameter int NUM_SLOTS   = 32,
  parameter int PREP_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [5:0]  cmdIndex,
  input  logic [31:0] cmdArg,
  input  logic        xferDone,
  input  logic        cfgEnable,
  input  logic [4:0]  cfgDepthN,
  input  logic [31:0] legacyStatus,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        errFlag,
  output logic        execStart,
  output logic [4:0]  execId,
  output logic        execRead,
  output logic        execHighPrio,
  output logic [31:0] execAddr,
  output logic [15:0] execCount
);
  qstrobe_t             strb;
  logic [MAX_TASKS-1:0] readyMap, busyMap, dirMap;

  cmdq_ctrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIndex(cmdIndex), .cmdArg(cmdArg),
    .cfgEnable(cfgEnable), .cfgDepthN(cfgDepthN), .legacyStatus(legacyStatus),
    .readyMap(readyMap), .busyMap(busyMap), .dirMap(dirMap), .strb(strb),
    .rspValid(rspValid), .rspData(rspData), .errFlag(errFlag)
  );

  cmdq_store #(.NUM_SLOTS(NUM_SLOTS), .PREP_CYCLES(PREP_CYCLES)) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .xferDone(xferDone),
    .readyMap(readyMap), .busyMap(busyMap), .dirMap(dirMap),
    .execStart(execStart), .execId(execId), .execRead(execRead),
    .execHighPrio(execHighPrio), .execAddr(execAddr), .execCount(execCount)
  );
endmodule

// File: rtl/cmdq_task_mgr_chk.sv
module cmdq_task_mgr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [5:0]  cmdIndex,
  input logic        statusSel,
  input logic        cfgEnable,
  input logic [4:0]  cfgDepthN,
  input logic        rspValid,
  input logic [31:0] rspData,
  input logic        errFlag,
  input logic        execStart,
  input logic        execRead
);
  logic [5:0] dEff;
  assign dEff = {1'b0, cfgDepthN} + 6'd1;

  // R5
  rsp_after_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(cmdValid && cmdIndex == 6'd13));

  // R10
  status_depth_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIndex == 6'd13 && statusSel) |=> ((rspData >> $past(dEff)) == 32'd0));

  // R7
  err_excl_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(errFlag && execStart));

  // R6
  exec_from_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    execStart |-> $past(cmdValid && cfgEnable && (cmdIndex == 6'd46 || cmdIndex == 6'd47)));

  // R6
  exec_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    execStart |-> (execRead == ($past(cmdIndex) == 6'd46)));

  // R11
  disabled_no_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !execStart);
endmodule

bind cmdq_task_mgr cmdq_task_mgr_chk chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIndex(cmdIndex),
  .statusSel(cmdArg[15]), .cfgEnable(cfgEnable), .cfgDepthN(cfgDepthN),
  .rspValid(rspValid), .rspData(rspData), .errFlag(errFlag),
  .execStart(execStart), .execRead(execRead)
);

// File: tb/cmdq_task_mgr_tb_top.sv
module cmdq_task_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PREP       = 3;
  localparam logic [31:0] LEGACY = 32'h0000_0900;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [5:0]  cmdIndex = '0;
  logic [31:0] cmdArg = '0;
  logic        xferDone = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [4:0]  cfgDepthN = '0;
  logic        rspValid, errFlag, execStart, execRead, execHighPrio;
  logic [31:0] rspData, execAddr;
  logic [4:0]  execId;
  logic [15:0] execCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_task_mgr #(.NUM_SLOTS(32), .PREP_CYCLES(PREP)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIndex(cmdIndex), .cmdArg(cmdArg),
    .xferDone(xferDone), .cfgEnable(cfgEnable), .cfgDepthN(cfgDepthN),
    .legacyStatus(LEGACY), .rspValid(rspValid), .rspData(rspData), .errFlag(errFlag),
    .execStart(execStart), .execId(execId), .execRead(execRead),
    .execHighPrio(execHighPrio), .execAddr(execAddr), .execCount(execCount)
  );

  int nTests = 0;
  int nFails = 0;

  // reference model: 0 unused, 1 pending, 2 ready, 3 active
  int          mSt[32];
  int          mCnt[32];
  bit          mDir[32], mPrio[32];
  bit [15:0]   mCount[32];
  bit [31:0]   mAddr[32];
  bit          sV = 0;
  int          sId = 0;
  bit          sDir = 0, sPrio = 0;
  bit [15:0]   sCnt = 0;
  bit          eRspV = 0, eErr = 0, eExec = 0, eRead = 0, ePrio = 0;
  bit [31:0]   eRspD = 0, eAddr = 0;
  bit [4:0]    eId = 0;
  bit [15:0]   eCount = 0;

  initial for (int i = 0; i < 32; i++) begin
    mSt[i] = 0; mCnt[i] = 0; mDir[i] = 0; mPrio[i] = 0; mCount[i] = 0; mAddr[i] = 0;
  end

  function automatic bit [31:0] prm(bit rd, bit pri, int id, int cnt);
    // reliable, tag, context and forced bits set to show they are ignored (R2)
    return {1'b1, rd, 1'b1, 4'hA, 1'b1, pri, 2'b11, 5'(id), 16'(cnt)};
  endfunction

  function automatic bit [31:0] tid(int id);
    return {11'd0, 5'(id), 16'd0};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit v, bit [5:0] idx, bit [31:0] arg, bit done);
    int depth, id;
    bit inR, cA, cO, cm, ex, err, rsp, ld;
    int tsel;
    bit [31:0] rdy;
    cmdValid = v; cmdIndex = idx; cmdArg = arg; xferDone = done;
    depth = int'(cfgDepthN) + 1;
    if (depth > 32) depth = 32;
    id = int'(arg[20:16]);
    inR = id < depth;
    rdy = 0;
    for (int i = 0; i < depth; i++) if (mSt[i] == 2) rdy[i] = 1;
    cA = !cfgEnable; cO = 0; cm = 0; ex = 0; err = 0; rsp = 0; ld = 0; tsel = 0;
    if (v) begin
      if (idx == 44) begin
        if (!cfgEnable || !inR) err = 1; else ld = 1;
      end else if (idx == 45) begin
        if (!cfgEnable || !sV || mSt[sId] != 0) err = 1;
        else begin cm = 1; tsel = sId; end
      end else if (idx == 46 || idx == 47) begin
        if (!cfgEnable || !inR || mSt[id] != 2 || mDir[id] != (idx == 46)) err = 1;
        else begin ex = 1; tsel = id; end
      end else if (idx == 48) begin
        if (!cfgEnable) err = 1;
        else if (arg[3:0] == 4'h1) cA = 1;
        else if (arg[3:0] == 4'h2 && inR) begin cO = 1; tsel = id; end
        else err = 1;
      end else if (idx == 13) rsp = 1;
    end
    eErr = err; eRspV = rsp; eExec = ex;
    if (rsp) eRspD = arg[15] ? rdy : LEGACY;
    if (ex) begin
      eId = 5'(tsel); eRead = mDir[tsel]; ePrio = mPrio[tsel];
      eAddr = mAddr[tsel]; eCount = mCount[tsel];
    end
    for (int i = 0; i < 32; i++) begin
      if (cA || (cO && i == tsel)) mSt[i] = 0;
      else if (cm && i == tsel) begin
        mSt[i] = 1; mCnt[i] = PREP; mDir[i] = sDir; mPrio[i] = sPrio;
        mCount[i] = sCnt; mAddr[i] = arg;
      end else if (ex && i == tsel) mSt[i] = 3;
      else if (mSt[i] == 1) begin
        if (mCnt[i] == 1) mSt[i] = 2; else mCnt[i]--;
      end else if (mSt[i] == 3 && done) mSt[i] = 0;
    end
    if (!cfgEnable) sV = 0;
    else if (v) sV = ld;
    if (ld) begin sId = id; sDir = arg[30]; sPrio = arg[23]; sCnt = arg[15:0]; end
    @(negedge clk);
    check(tag, {rspValid, errFlag, execStart, execRead, execHighPrio, execId, rspData, 22'd0},
               {eRspV, eErr, eExec, eRead, ePrio, eId, eRspD, 22'd0});
    if (eExec) check(tag, {execAddr, 16'd0, execCount}, {eAddr, 16'd0, eCount});
    cmdValid = 0; xferDone = 0;
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) cyc(tag, 0, 6'd0, 32'd0, 0);
  endtask

  task automatic cmd(string tag, bit [5:0] idx, bit [31:0] arg);
    cyc(tag, 1, idx, arg, 0);
  endtask

  task automatic queue(string tag, bit rd, bit pri, int id, int cnt, bit [31:0] addr);
    cmd(tag, 6'd44, prm(rd, pri, id, cnt));
    cmd(tag, 6'd45, addr);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {rspValid, errFlag, execStart}, 3'b000);
    rstN = 1;
    idle("R1", 2);
    cmd("R1", 6'd13, 32'h8000);
    check("R1 empty status", rspData, 0);

    cfgEnable = 1; cfgDepthN = 5'd7;
    queue("R2", 1, 1, 3, 16'h0010, 32'h0000_1000);
    cmd("R3", 6'd13, 32'h8000);
    check("R3 pending not ready", rspData, 0);
    idle("R3", 1);
    cmd("R12", 6'd13, 32'h8000);
    check("R12 status on ready edge", rspData, 0);
    cmd("R3", 6'd13, 32'h8000);
    check("R3 ready bit", rspData, 32'h8);
    cmd("R5", 6'd13, 32'h0000_7fff);
    check("R5 legacy", rspData, LEGACY);

    cmd("R7", 6'd47, tid(3));
    check("R7 dir mismatch", errFlag, 1);
    cmd("R7", 6'd46, tid(5));
    check("R7 not ready", errFlag, 1);
    cmd("R7", 6'd46, tid(9));
    check("R7 out of depth", errFlag, 1);

    cmd("R6", 6'd46, tid(3));
    check("R6 exec fields", {execStart, execId, execRead, execHighPrio, execAddr, execCount},
          {1'b1, 5'd3, 1'b1, 1'b1, 32'h0000_1000, 16'h0010});
    cmd("R6", 6'd13, 32'h8000);
    check("R6 active not ready", rspData, 0);
    cyc("R8", 0, 6'd0, 32'd0, 1);
    queue("R8", 0, 0, 3, 4, 32'h0000_2000);
    check("R8 id reusable", errFlag, 0);
    queue("R12", 1, 0, 1, 8, 32'h0000_3000);
    idle("R12", PREP);
    cmd("R12", 6'd47, tid(3));
    cyc("R12", 1, 6'd46, tid(1), 1);
    check("R12 exec wins", {execStart, execId}, {1'b1, 5'd1});
    queue("R4", 0, 0, 1, 2, 32'h10);
    check("R4 slot in use", errFlag, 1);
    queue("R12", 0, 0, 3, 2, 32'h20);
    check("R12 done freed other slot", errFlag, 0);
    cyc("R8", 0, 6'd0, 32'd0, 1);

    cmd("R4", 6'd45, 32'h44);
    check("R4 lone address", errFlag, 1);
    cmd("R4", 6'd44, prm(0, 0, 5, 1));
    cmd("R4", 6'd13, 32'h8000);
    cmd("R4", 6'd45, 32'h55);
    check("R4 broken pair", errFlag, 1);

    cmd("R10", 6'd44, prm(0, 0, 9, 1));
    check("R10 id over depth", errFlag, 1);
    cfgDepthN = 5'd31;
    queue("R10", 0, 1, 20, 2, 32'h77);
    idle("R10", PREP);
    cmd("R10", 6'd13, 32'h8000);
    check("R10 high id", rspData & 32'h0010_0000, 32'h0010_0000);
    cfgDepthN = 5'd7;
    cmd("R10", 6'd13, 32'h8000);
    check("R10 masked", rspData & 32'hffff_ff00, 0);

    cmd("R9", 6'd48, tid(20) | 32'h2);
    check("R9 clear out of range", errFlag, 1);
    cfgDepthN = 5'd31;
    cmd("R9", 6'd48, tid(20) | 32'h2);
    cmd("R9", 6'd13, 32'h8000);
    check("R9 clear one", rspData & 32'h0010_0000, 0);
    queue("R9", 0, 0, 2, 1, 32'h1);
    queue("R9", 1, 0, 4, 1, 32'h2);
    idle("R9", PREP);
    cmd("R9", 6'd48, 32'h1);
    cmd("R9", 6'd13, 32'h8000);
    check("R9 clear all", rspData, 0);
    cmd("R9", 6'd48, 32'h5);
    check("R9 bad opcode", errFlag, 1);

    queue("R12", 0, 0, 6, 1, 32'h6);
    idle("R12", PREP - 1);
    cmd("R12", 6'd48, tid(6) | 32'h2);
    idle("R12", 2);
    cmd("R12", 6'd13, 32'h8000);
    check("R12 clear beats ready", rspData, 0);
    queue("R12", 0, 0, 6, 1, 32'h6);
    check("R12 slot free after clear", errFlag, 0);

    queue("R11", 1, 0, 7, 1, 32'h7);
    idle("R11", PREP);
    cfgEnable = 0;
    idle("R11", 1);
    cmd("R11", 6'd13, 32'h8000);
    check("R11 status while off", {rspValid, rspData}, {1'b1, 32'd0});
    cmd("R11", 6'd44, prm(0, 0, 1, 1));
    check("R11 queue cmd rejected", errFlag, 1);
    cfgEnable = 1;
    cmd("R11", 6'd13, 32'h8000);
    check("R11 cleared", rspData, 0);
    idle("R1", 2);

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule